// File: doc/BRIEF.md
# Burst-of-Two Memory Model with Data Inversion

A synthesizable, cycle-accurate model of a common-I/O memory that moves data in bursts of two beats. It serves as a target for exercising a memory controller. Each clock it takes at most one command: a load strobe, a read/write select and a word index. Every array word is twice as wide as the data bus. A write collects two incoming beats and stores them together. A read fetches one array word and sends it back as two beats at a fixed latency. A valid flag runs one cycle ahead of each beat.

The data bus is split into 9-bit groups, and each group carries its own inversion flag. While inversion is enabled, a write flag of 1 means the arriving group is inverted and is restored before storage. On reads, the model inverts any group holding more zeros than ones and raises that group's flag. In this single-clock model a beat lasts one clock. Commands therefore need one idle cycle between them, and the model ignores a command in the cycle right after an accepted one.

Top module: `b2_inv_sram`

## Requirements
- R1: At most one command is accepted per cycle. A cycle with `cmd_en` low is a no-op. A command in the cycle directly after an accepted command is ignored and does not change the array.
- R2: An accepted command with `cmd_rd` = 1 is a read. With `cmd_rd` = 0 it is a write.
- R3: For a write accepted in cycle c, beat 0 is taken from `wr_data`/`wr_flag` in cycle c+1 and beat 1 in cycle c+2. Both beats are stored together in the one double-width word selected by `cmd_addr`.
- R4: For a read accepted in cycle c, beat 0 (the word's first-written beat) appears on `rd_data` in cycle c+6 and beat 1 in cycle c+7.
- R5: `rd_valid` is 1 in exactly the cycles that directly precede a read beat, which are c+5 and c+6.
- R6: `rd_data` and `rd_flag` are 0 in every cycle that carries no read beat.
- R7: With `inv_en` = 0, `wr_flag` is ignored and beats are stored as received. `rd_flag` is 0, and the stored data is returned unchanged.
- R8: Flag bit k covers data bits 9k+8:9k. With `inv_en` = 1, a write flag of 1 inverts that group before storage. On a read, a group holding 5 or more zeros is sent inverted with its flag at 1. A group with 4 or fewer zeros is sent as stored with its flag at 0.
- R9: A read of a written address returns the written beats, once each group flagged 1 is inverted back.
- R10: While `rst` is 1, all outputs are 0. A write or read that has not completed is abandoned: no beats follow, and the array keeps its earlier content.
- R11: A read accepted in the same cycle as a write's beat 1, to the same address, returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_en | input | 1 | Load strobe: command present |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | ADDR_W | Double-width word index |
| inv_en | input | 1 | Enables data inversion handling |
| wr_data | input | GRP_BITS*GROUPS | Write beat data |
| wr_flag | input | GROUPS | Write inversion flag per 9-bit group |
| rd_data | output | GRP_BITS*GROUPS | Read beat data |
| rd_flag | output | GROUPS | Read inversion flag per 9-bit group |
| rd_valid | output | 1 | High one cycle before each read beat |

## Verification
The assertions check on every cycle the rules that hold locally in time. These are the spacing between accepted commands, `rd_valid` leading each beat and the two beats arriving as a pair, quiet outputs between beats, zero flags while inversion is off, and the majority rule for every flagged group. Only the bench scenarios can show that the right word returns after exactly six cycles in the right beat order. The same holds for ignored commands leaving the array untouched, for inverted writes being restored, for the 4-versus-5-zero boundary, for a read placed on a write's last beat, and for reset abandoning work in progress.

// File: rtl/b2_inv_sram.sv
module b2_inv_sram #(
  parameter int GRP_BITS = 9,
  parameter int GROUPS   = 2,
  parameter int ADDR_W   = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmd_en,
  input  logic                       cmd_rd,
  input  logic [ADDR_W-1:0]          cmd_addr,
  input  logic                       inv_en,
  input  logic [GRP_BITS*GROUPS-1:0] wr_data,
  input  logic [GROUPS-1:0]          wr_flag,
  output logic [GRP_BITS*GROUPS-1:0] rd_data,
  output logic [GROUPS-1:0]          rd_flag,
  output logic                       rd_valid
);
  localparam int DW    = GRP_BITS * GROUPS;
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [DW-1:0] grp_mask(input logic [GROUPS-1:0] f);
    logic [DW-1:0] m;
    m = '0;
    for (int g = 0; g < GROUPS; g++)
      if (f[g]) m[g*GRP_BITS +: GRP_BITS] = '1;
    return m;
  endfunction

  function automatic logic [GROUPS-1:0] zero_heavy(input logic [DW-1:0] w);
    logic [GROUPS-1:0] f;
    for (int g = 0; g < GROUPS; g++)
      f[g] = (2 * (GRP_BITS - $countones(w[g*GRP_BITS +: GRP_BITS]))) > GRP_BITS;
    return f;
  endfunction

  logic [2*DW-1:0]   mem [DEPTH];
  logic [1:0]        wsh;
  logic [5:0]        rsh;
  logic [ADDR_W-1:0] a_q, a_d1, a_d2;
  logic [DW-1:0]     wlo, nxt_data;
  logic [2*DW-1:0]   hold;
  logic [GROUPS-1:0] nxt_flag, f_lo, f_hi;
  logic              ov;

  wire           busy   = wsh[0] | rsh[0];
  wire           accept = cmd_en & ~busy;
  wire [DW-1:0]  wclean = wr_data ^ grp_mask(inv_en ? wr_flag : '0);

  assign f_lo = inv_en ? zero_heavy(hold[DW-1:0])    : '0;
  assign f_hi = inv_en ? zero_heavy(hold[2*DW-1:DW]) : '0;

  always_ff @(posedge clk) begin
    a_q  <= accept ? cmd_addr : a_q;
    a_d1 <= a_q;
    a_d2 <= a_d1;
    if (wsh[0]) wlo <= wclean;
    if (!rst && wsh[1]) mem[a_d1] <= {wclean, wlo};
    if (rsh[2]) hold <= mem[a_d2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wsh      <= '0;
      rsh      <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_flag  <= '0;
      nxt_data <= '0;
      nxt_flag <= '0;
      ov       <= 1'b0;
    end else begin
      wsh      <= {wsh[0], accept & ~cmd_rd};
      rsh      <= {rsh[4:0], accept & cmd_rd};
      rd_valid <= rsh[3] | rsh[4];
      if (rsh[4]) begin
        rd_data  <= hold[DW-1:0] ^ grp_mask(f_lo);
        rd_flag  <= f_lo;
        nxt_data <= hold[2*DW-1:DW] ^ grp_mask(f_hi);
        nxt_flag <= f_hi;
        ov       <= 1'b1;
      end else if (rsh[5]) begin
        rd_data <= nxt_data;
        rd_flag <= nxt_flag;
        ov      <= 1'b1;
      end else begin
        rd_data <= '0;
        rd_flag <= '0;
        ov      <= 1'b0;
      end
    end
  end

  AST_CMD_SPACING: assert property (@(posedge clk) disable iff (rst) accept |=> !accept); // R1
  AST_VALID_LEADS: assert property (@(posedge clk) disable iff (rst) ov |-> $past(rd_valid)); // R5
  AST_VALID_FOLLOWED: assert property (@(posedge clk) disable iff (rst) rd_valid |=> ov); // R5
  AST_BEAT_PAIR: assert property (@(posedge clk) disable iff (rst) $rose(ov) |=> ov); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !ov |-> (rd_data == '0 && rd_flag == '0)); // R6
  AST_FLAG_OFF: assert property (@(posedge clk) disable iff (rst) (!$past(inv_en) && !$past(inv_en, 2)) |-> rd_flag == '0); // R7

  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    AST_FLAG_MAJORITY: assert property (@(posedge clk) disable iff (rst)
      rd_flag[g] |-> (2 * $countones(rd_data[g*GRP_BITS +: GRP_BITS])) > GRP_BITS); // R8
  end
endmodule

// File: tb/sim_b2_inv_sram.sv
module sim_b2_inv_sram;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 18;
  localparam int AW = 6;

  logic clk = 0, rst = 1;
  logic cmd_en = 0, cmd_rd = 0, inv_en = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0] wr_flag = '0;
  logic [DW-1:0] rd_data;
  logic [1:0] rd_flag;
  logic rd_valid;

  b2_inv_sram #(.GRP_BITS(9), .GROUPS(2), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .cmd_en(cmd_en), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr),
    .inv_en(inv_en), .wr_data(wr_data), .wr_flag(wr_flag),
    .rd_data(rd_data), .rd_flag(rd_flag), .rd_valid(rd_valid));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int cyc; logic [DW-1:0] d; logic [1:0] f; string tag; } item_t;
  item_t q[$];
  logic [2*DW-1:0] model [int];
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit prev_valid = 0, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] mask(input logic [1:0] f);
    return {{9{f[1]}}, {9{f[0]}}};
  endfunction

  function automatic logic [1:0] heavy(input logic [DW-1:0] w);
    logic [1:0] f;
    for (int g = 0; g < 2; g++) begin
      int z = 0;
      for (int b = 0; b < 9; b++) if (!w[g*9+b]) z++;
      f[g] = (z >= 5);
    end
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_beat(input int c, input logic [DW-1:0] stored, input string tag);
    item_t it;
    logic [1:0] f;
    f = inv_en ? heavy(stored) : 2'b00;
    it.cyc = c; it.d = stored ^ mask(f); it.f = f; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!done) begin
      if (q.size() > 0 && q[0].cyc == cyc) begin
        chk(rd_data == q[0].d, {q[0].tag, " R4 R9 beat data"}, rd_data, q[0].d);
        chk(rd_flag == q[0].f, {q[0].tag, " R8 beat flag"}, rd_flag, q[0].f);
        chk(prev_valid, "R5 valid before beat", prev_valid, 1);
        void'(q.pop_front());
      end else begin
        chk(rd_data == '0 && rd_flag == '0, "R6 quiet outputs", {rd_flag, rd_data}, 0);
      end
      chk(rd_valid == (q.size() > 0 && q[0].cyc == cyc + 1), "R5 valid timing",
          rd_valid, (q.size() > 0 && q[0].cyc == cyc + 1));
      prev_valid = rd_valid;
    end
  end

  task automatic idle();
    cmd_en = 0; cmd_rd = 0; wr_data = '0; wr_flag = '0;
  endtask

  // write: command, beat0, beat1; optional read of same address on beat1 cycle (R11)
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] b0, input logic [DW-1:0] b1,
                    input logic [1:0] f0, input logic [1:0] f1, input bit rd_after, input string tag);
    logic [DW-1:0] c0, c1;
    int c;
    c = cyc;
    cmd_en = 1; cmd_rd = 0; cmd_addr = a;
    @(negedge clk);
    cmd_en = 0; wr_data = b0; wr_flag = f0;
    @(negedge clk);
    wr_data = b1; wr_flag = f1;
    c0 = b0 ^ (inv_en ? mask(f0) : '0);
    c1 = b1 ^ (inv_en ? mask(f1) : '0);
    model[int'(a)] = {c1, c0};
    if (rd_after) begin
      cmd_en = 1; cmd_rd = 1; cmd_addr = a;
      expect_beat(c + 2 + 6, c0, tag);
      expect_beat(c + 2 + 7, c1, tag);
    end
    @(negedge clk);
    idle();
    if (rd_after) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    logic [2*DW-1:0] w;
    w = model[int'(a)];
    cmd_en = 1; cmd_rd = 1; cmd_addr = a;
    expect_beat(cyc + 6, w[DW-1:0], tag);
    expect_beat(cyc + 7, w[2*DW-1:DW], tag);
    @(negedge clk);
    idle();
    @(negedge clk);
  endtask

  task automatic drain();
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_data == '0 && rd_flag == '0 && !rd_valid, "R10 reset outputs", {rd_valid, rd_flag, rd_data}, 0);
    rst = 0;
    @(negedge clk);

    // R2 R3 R7: plain write/read, inversion off, flags ignored
    inv_en = 0;
    wr(6'd1, 18'h00000, 18'h3FFFF, 2'b11, 2'b11, 0, "R7");
    wr(6'd2, 18'h12345, 18'h0ABCD, 2'b00, 2'b00, 0, "R3");
    wr(6'd63, 18'h2AAAA, 18'h15555, 2'b10, 2'b01, 0, "R3");
    rd(6'd1, "R7");
    rd(6'd2, "R2");
    rd(6'd63, "R3");
    drain();

    // R1: cmd_en low with other inputs busy is a no-op; command right after accepted one ignored
    cmd_en = 0; cmd_rd = 0; cmd_addr = 6'd2; wr_data = 18'h3FFFF;
    @(negedge clk);
    idle();
    cmd_en = 1; cmd_rd = 1; cmd_addr = 6'd63;
    expect_beat(cyc + 6, model[63][DW-1:0], "R1");
    expect_beat(cyc + 7, model[63][2*DW-1:DW], "R1");
    @(negedge clk);
    cmd_en = 1; cmd_rd = 0; cmd_addr = 6'd2;
    @(negedge clk);
    cmd_en = 0; wr_data = 18'h3FFFF; wr_flag = 2'b11;
    @(negedge clk);
    wr_data = 18'h1F0F0;
    @(negedge clk);
    idle();
    drain();
    rd(6'd2, "R1");
    drain();

    // R8 R9: inversion on, flagged writes restored, read majority incl. 4/5-zero boundary
    inv_en = 1;
    wr(6'd5, 18'h3FFFF ^ 18'h0001F, 18'h00000, 2'b01, 2'b00, 0, "R8");
    wr(6'd6, {9'b000011111, 9'b000001111}, {9'b111110000, 9'b100000000}, 2'b00, 2'b00, 0, "R8");
    wr(6'd7, 18'h15A5A, 18'h0F0F0, 2'b10, 2'b11, 0, "R9");
    rd(6'd5, "R8");
    rd(6'd6, "R8");
    rd(6'd7, "R9");
    rd(6'd2, "R9");
    drain();

    // R11: read on beat-1 cycle of a write to the same address
    wr(6'd9, 18'h00F0F, 18'h3C3C3, 2'b00, 2'b01, 1, "R11");
    wr(6'd10, 18'h11111, 18'h22222, 2'b00, 2'b00, 1, "R11");
    drain();

    // R10: write abandoned by reset on beat-1 cycle
    begin
      logic [2*DW-1:0] keep;
      keep = model[7];
      cmd_en = 1; cmd_rd = 0; cmd_addr = 6'd7;
      @(negedge clk);
      cmd_en = 0; wr_data = 18'h3FFFF; wr_flag = 2'b00;
      @(negedge clk);
      wr_data = 18'h00001; rst = 1;
      @(negedge clk);
      idle();
      chk(rd_data == '0 && !rd_valid, "R10 outputs in reset", {rd_valid, rd_data}, 0);
      rst = 0;
      @(negedge clk);
      model[7] = keep;
      rd(6'd7, "R10");
      drain();
    end

    // R10: read abandoned by reset mid-pipeline, no beats follow
    cmd_en = 1; cmd_rd = 1; cmd_addr = 6'd5;
    @(negedge clk);
    idle();
    repeat (2) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    repeat (8) @(negedge clk);
    chk(q.size() == 0, "R10 no stray beats", q.size(), 0);
    rd(6'd5, "R10");
    drain();

    chk(q.size() == 0, "R4 all beats seen", q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule